// File: doc/BRIEF.md
# I2S Sample Packer

This block sits between two byte-wide FIFOs and the sample port of an audio codec. A codec-side request gives a transmit count and a receive count in samples. For transmit, the block pops bytes from the transmit FIFO and assembles each sample low byte first. It then offers the sample on a valid/ready port. For receive, it accepts whole samples from the codec on a second valid/ready port. It splits each sample into bytes, low byte first, and pushes them into the receive FIFO. The transmit phase always runs before the receive phase.

The sample width is chosen in whole bytes. A request is served only when the port is enabled and the protocol selector names I2S. If the transmit FIFO runs dry while requested bytes remain, the block raises a sticky underrun flag. If the receive FIFO fills while bytes remain to be stored, it raises a sticky overrun flag. While a request is being served, `busy_o` is high. A one-cycle `done_o` marks the end of the request, so that FIFO threshold status can be evaluated again.

Top module: `i2s_sample_packer`

## Requirements
- R1: A request on `req_i` is served only when `en_i` is 1 and `proto_i` equals 3 (I2S). Otherwise the request is ignored: busy and done stay low, no byte is popped or pushed, and no flag changes.
- R2: The transmit phase runs only when both `tx_en_i` and `tx_oe_i` are 1. The receive phase runs only when `rx_en_i` is 1. A disabled direction moves no data and raises no flag.
- R3: Each sample has `bps_i`+1 bytes. The k-th byte popped for a sample lands in bits [8k+7:8k] of `tx_smp_o`, and lanes above the sample width read as zero. `tx_smp_valid_o` and `tx_smp_o` hold steady until `tx_smp_ready_i` accepts the sample.
- R4: A codec sample accepted on the receive port is pushed as `bps_i`+1 bytes, starting with bits [7:0] and moving up one byte per push.
- R5: If the transmit FIFO is empty while requested bytes remain, `udr_o` is set and the transmit phase stops. A partly built sample is dropped and never presented. The block never pops an empty FIFO.
- R6: If the receive FIFO is full while bytes remain to be stored, `ovr_o` is set and the receive phase stops. The block never pushes into a full FIFO, and it accepts no codec sample while the FIFO is full.
- R7: `udr_o` and `ovr_o` stay set until `err_clr_i` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R8: `busy_o` rises in the cycle after an accepted request and falls right after a single-cycle `done_o`.
- R9: A request whose active directions both have a count of zero completes with one `done_o`, moves no data and leaves the flags unchanged.
- R10: At most one of FIFO pop, FIFO push, transmit-valid and receive-ready is active in any cycle, and none of them is active while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| proto_i | input | 3 | Protocol selector, 3 = I2S |
| tx_en_i | input | 1 | Transmit enable |
| tx_oe_i | input | 1 | Transmit data output enable |
| rx_en_i | input | 1 | Receive enable |
| bps_i | input | IDX_W | Bytes per sample minus one |
| req_i | input | 1 | Codec data request strobe |
| tx_cnt_i | input | CNT_W | Requested transmit samples |
| rx_cnt_i | input | CNT_W | Offered receive samples |
| err_clr_i | input | 1 | Clears both sticky flags |
| txf_data_i | input | BYTE_W | Head byte of the transmit FIFO |
| txf_empty_i | input | 1 | Transmit FIFO empty |
| txf_pop_o | output | 1 | Pop the transmit FIFO |
| rxf_full_i | input | 1 | Receive FIFO full |
| rxf_data_o | output | BYTE_W | Byte to push into the receive FIFO |
| rxf_push_o | output | 1 | Push the receive FIFO |
| tx_smp_o | output | SMP_W | Transmit sample to the codec |
| tx_smp_valid_o | output | 1 | Transmit sample valid |
| tx_smp_ready_i | input | 1 | Codec accepts the transmit sample |
| rx_smp_i | input | SMP_W | Receive sample from the codec |
| rx_smp_valid_i | input | 1 | Receive sample valid |
| rx_smp_ready_o | output | 1 | Block accepts the receive sample |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished, single-cycle pulse |
| udr_o | output | 1 | Sticky transmit underrun |
| ovr_o | output | 1 | Sticky receive overrun |

## Verification
The bench targets FIFO exhaustion at sample boundaries and in the middle of a sample, in both directions. A design that checks only at sample boundaries would push past a full receive FIFO, or would present a half-built transmit sample. Samples of odd width (three bytes) are run against codec ports that stall on alternate cycles. A byte order error or a sample that changes while waiting for ready would show up as wrong sample values. Gated requests, zero counts and a disabled direction next to an active one are also covered. So are flags that must survive a later clean request, which a design that clears them on every request would lose.

// File: rtl/i2s_pack_pkg.sv
package i2s_pack_pkg;
  localparam logic [2:0] PROTO_I2S = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_POP,
    ST_TX_SEND,
    ST_RX_TAKE,
    ST_RX_PUSH,
    ST_DONE
  } xfer_st_e;
endpackage

// File: rtl/i2s_err_flags.sv
module i2s_err_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic udr_set_i,
  input  logic ovr_set_i,
  input  logic clr_i,
  output logic udr_o,
  output logic ovr_o
);
  logic udr_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      udr_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (udr_set_i)  udr_q <= 1'b1;
      else if (clr_i) udr_q <= 1'b0;
      if (ovr_set_i)  ovr_q <= 1'b1;
      else if (clr_i) ovr_q <= 1'b0;
    end
  end

  assign udr_o = udr_q;
  assign ovr_o = ovr_q;

  assert_udr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udr_q && !clr_i) |=> udr_q);
  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_i) |=> ovr_q);
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udr_set_i && clr_i) |=> udr_q);
endmodule

// File: rtl/i2s_tx_packer.sv
module i2s_tx_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int SMP_W = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [SMP_W-1:0]  smp_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (load_i) begin
        // first byte of a sample clears the upper lanes
        if (idx_i == IDX_W'(g))     lane_q <= byte_i;
        else if (idx_i == '0)       lane_q <= '0;
      end
    end
    assign smp_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/i2s_rx_unpacker.sv
module i2s_rx_unpacker #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int SMP_W = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [SMP_W-1:0]  smp_q;
  logic [BYTE_W-1:0] lane_w [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    smp_q <= '0;
    else if (cap_i) smp_q <= smp_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign lane_w[g] = smp_q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = lane_w[0];
    for (int i = 0; i < LANES; i++) begin
      if (idx_i == IDX_W'(i)) byte_o = lane_w[i];
    end
  end
endmodule

// File: rtl/i2s_xfer_ctrl.sv
module i2s_xfer_ctrl
  import i2s_pack_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             go_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [IDX_W-1:0] bps_i,
  input  logic             txf_empty_i,
  output logic             txf_pop_o,
  output logic             tx_load_o,
  output logic             tx_smp_valid_o,
  input  logic             tx_smp_ready_i,
  input  logic             rx_smp_valid_i,
  output logic             rx_smp_ready_o,
  output logic             rx_cap_o,
  input  logic             rxf_full_i,
  output logic             rxf_push_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             udr_set_o,
  output logic             ovr_set_o,
  output logic             busy_o,
  output logic             done_o
);
  xfer_st_e         state_q, state_d;
  logic [CNT_W-1:0] tx_left_q, tx_left_d, rx_left_q, rx_left_d;
  logic [IDX_W-1:0] idx_q, idx_d, bps_q, bps_d;
  logic             rx_ok_q, rx_ok_d;
  xfer_st_e         rx_next;

  assign rx_next = (rx_ok_q && rx_left_q != '0) ? ST_RX_TAKE : ST_DONE;

  always_comb begin
    state_d        = state_q;
    tx_left_d      = tx_left_q;
    rx_left_d      = rx_left_q;
    idx_d          = idx_q;
    bps_d          = bps_q;
    rx_ok_d        = rx_ok_q;
    txf_pop_o      = 1'b0;
    tx_load_o      = 1'b0;
    tx_smp_valid_o = 1'b0;
    rx_smp_ready_o = 1'b0;
    rx_cap_o       = 1'b0;
    rxf_push_o     = 1'b0;
    udr_set_o      = 1'b0;
    ovr_set_o      = 1'b0;
    done_o         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && go_i) begin
          tx_left_d = tx_cnt_i;
          rx_left_d = rx_cnt_i;
          bps_d     = bps_i;
          rx_ok_d   = rx_ok_i;
          idx_d     = '0;
          if (tx_ok_i && tx_cnt_i != '0)      state_d = ST_TX_POP;
          else if (rx_ok_i && rx_cnt_i != '0) state_d = ST_RX_TAKE;
          else                                state_d = ST_DONE;
        end
      end
      ST_TX_POP: begin
        if (txf_empty_i) begin
          udr_set_o = 1'b1;
          idx_d     = '0;
          state_d   = rx_next;
        end else begin
          txf_pop_o = 1'b1;
          tx_load_o = 1'b1;
          if (idx_q == bps_q) begin
            idx_d   = '0;
            state_d = ST_TX_SEND;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_TX_SEND: begin
        tx_smp_valid_o = 1'b1;
        if (tx_smp_ready_i) begin
          tx_left_d = tx_left_q - 1'b1;
          state_d   = (tx_left_q == CNT_W'(1)) ? rx_next : ST_TX_POP;
        end
      end
      ST_RX_TAKE: begin
        if (rxf_full_i) begin
          ovr_set_o = 1'b1;
          state_d   = ST_DONE;
        end else begin
          rx_smp_ready_o = 1'b1;
          if (rx_smp_valid_i) begin
            rx_cap_o = 1'b1;
            idx_d    = '0;
            state_d  = ST_RX_PUSH;
          end
        end
      end
      ST_RX_PUSH: begin
        if (rxf_full_i) begin
          ovr_set_o = 1'b1;
          idx_d     = '0;
          state_d   = ST_DONE;
        end else begin
          rxf_push_o = 1'b1;
          if (idx_q == bps_q) begin
            idx_d     = '0;
            rx_left_d = rx_left_q - 1'b1;
            state_d   = (rx_left_q == CNT_W'(1)) ? ST_DONE : ST_RX_TAKE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tx_left_q <= '0;
      rx_left_q <= '0;
      idx_q     <= '0;
      bps_q     <= '0;
      rx_ok_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      tx_left_q <= tx_left_d;
      rx_left_q <= rx_left_d;
      idx_q     <= idx_d;
      bps_q     <= bps_d;
      rx_ok_q   <= rx_ok_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign idx_o  = idx_q;

  assert_no_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txf_pop_o |-> !txf_empty_i);
  assert_no_push_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_push_o |-> !rxf_full_i);
  assert_no_take_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_smp_ready_o |-> !rxf_full_i);
  assert_gate_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && !go_i) |=> !busy_o);
  assert_done_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_one_action_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({txf_pop_o, rxf_push_o, tx_smp_valid_o, rx_smp_ready_o}));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(txf_pop_o || rxf_push_o || tx_smp_valid_o || rx_smp_ready_o));
endmodule

// File: rtl/i2s_sample_packer.sv
module i2s_sample_packer
  import i2s_pack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int SMP_W = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        proto_i,
  input  logic              tx_en_i,
  input  logic              tx_oe_i,
  input  logic              rx_en_i,
  input  logic [IDX_W-1:0]  bps_i,
  input  logic              req_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              err_clr_i,
  input  logic [BYTE_W-1:0] txf_data_i,
  input  logic              txf_empty_i,
  output logic              txf_pop_o,
  input  logic              rxf_full_i,
  output logic [BYTE_W-1:0] rxf_data_o,
  output logic              rxf_push_o,
  output logic [SMP_W-1:0]  tx_smp_o,
  output logic              tx_smp_valid_o,
  input  logic              tx_smp_ready_i,
  input  logic [SMP_W-1:0]  rx_smp_i,
  input  logic              rx_smp_valid_i,
  output logic              rx_smp_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              udr_o,
  output logic              ovr_o
);
  logic             go, tx_ok, rx_ok;
  logic             tx_load, rx_cap, udr_set, ovr_set;
  logic [IDX_W-1:0] idx;

  assign go    = en_i && (proto_i == PROTO_I2S);
  assign tx_ok = tx_en_i && tx_oe_i;
  assign rx_ok = rx_en_i;

  i2s_xfer_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_ctrl (
    .clk_i, .rst_ni,
    .req_i, .go_i(go), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
    .tx_cnt_i, .rx_cnt_i, .bps_i,
    .txf_empty_i, .txf_pop_o, .tx_load_o(tx_load),
    .tx_smp_valid_o, .tx_smp_ready_i,
    .rx_smp_valid_i, .rx_smp_ready_o, .rx_cap_o(rx_cap),
    .rxf_full_i, .rxf_push_o, .idx_o(idx),
    .udr_set_o(udr_set), .ovr_set_o(ovr_set),
    .busy_o, .done_o
  );

  i2s_tx_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) i_tx_pack (
    .clk_i, .rst_ni, .load_i(tx_load), .idx_i(idx),
    .byte_i(txf_data_i), .smp_o(tx_smp_o)
  );

  i2s_rx_unpacker #(.BYTE_W(BYTE_W), .LANES(LANES)) i_rx_unpack (
    .clk_i, .rst_ni, .cap_i(rx_cap), .smp_i(rx_smp_i),
    .idx_i(idx), .byte_o(rxf_data_o)
  );

  i2s_err_flags i_flags (
    .clk_i, .rst_ni, .udr_set_i(udr_set), .ovr_set_i(ovr_set),
    .clr_i(err_clr_i), .udr_o, .ovr_o
  );

  assert_tx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_smp_valid_o && !tx_smp_ready_i) |=> (tx_smp_valid_o && $stable(tx_smp_o)));
  assert_push_after_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_smp_ready_o && rx_smp_valid_i) |=> (rxf_push_o || ovr_o));
endmodule

// File: tb/test_i2s_sample_packer.sv
module test_i2s_sample_packer;
  localparam int CLK_P  = 10;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int CNT_W  = 8;
  localparam int SMP_W  = BYTE_W * LANES;

  typedef struct packed {
    int tc; int rc; int bps; int fill; int room;
    bit en; bit [2:0] proto; bit txen; bit txoe; bit rxen; bit stall;
    int ntx; int nrx; bit udr; bit ovr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3, 2, 3, 12, 8, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 3, 8, 1'b0, 1'b0},
    '{4, 0, 1,  5, 0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2, 0, 1'b1, 1'b0},
    '{0, 3, 0,  0, 2, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 0, 2, 1'b0, 1'b1},
    '{2, 2, 2,  6, 4, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 2, 4, 1'b0, 1'b1},
    '{0, 0, 0,  4, 4, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0},
    '{2, 2, 0,  4, 4, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0},
    '{2, 2, 0,  4, 4, 1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0},
    '{2, 1, 0,  4, 4, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1, 1'b0, 1'b0},
    '{1, 2, 3,  4, 0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1, 0, 1'b0, 1'b0},
    '{3, 3, 1,  6, 3, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 3, 3, 1'b0, 1'b1},
    '{1, 1, 0,  0, 0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0, 1'b1, 1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, tx_en_i = 0, tx_oe_i = 0, rx_en_i = 0, req_i = 0, err_clr_i = 0;
  logic [2:0] proto_i = 0;
  logic [1:0] bps_i = 0;
  logic [CNT_W-1:0] tx_cnt_i = 0, rx_cnt_i = 0;
  logic [BYTE_W-1:0] txf_data_i, rxf_data_o;
  logic txf_empty_i, txf_pop_o, rxf_full_i, rxf_push_o;
  logic [SMP_W-1:0] tx_smp_o, rx_smp_i;
  logic tx_smp_valid_o, tx_smp_ready_i, rx_smp_valid_i, rx_smp_ready_o;
  logic busy_o, done_o, udr_o, ovr_o;

  int checks = 0, errors = 0;
  logic model_clr = 0, stall = 0;
  int tx_fill = 0, rx_room = 0;
  int tx_rd, rx_n, tx_n, src_n, done_n, busy_n, cyc;
  logic [BYTE_W-1:0] rx_got [64];
  logic [SMP_W-1:0]  tx_got [64];

  always #(CLK_P/2) clk_i = ~clk_i;

  i2s_sample_packer #(.BYTE_W(BYTE_W), .LANES(LANES), .CNT_W(CNT_W)) i_i2s_sample_packer (
    .clk_i, .rst_ni, .en_i, .proto_i, .tx_en_i, .tx_oe_i, .rx_en_i, .bps_i,
    .req_i, .tx_cnt_i, .rx_cnt_i, .err_clr_i,
    .txf_data_i, .txf_empty_i, .txf_pop_o, .rxf_full_i, .rxf_data_o, .rxf_push_o,
    .tx_smp_o, .tx_smp_valid_o, .tx_smp_ready_i,
    .rx_smp_i, .rx_smp_valid_i, .rx_smp_ready_o,
    .busy_o, .done_o, .udr_o, .ovr_o
  );

  function automatic logic [7:0] tx_pat(int k);
    return 8'(8'h51 + k * 13);
  endfunction
  function automatic logic [7:0] rx_pat(int i, int j);
    return 8'(8'h80 + i * 16 + j + 1);
  endfunction

  // bench-side FIFO and codec models
  assign txf_data_i  = tx_pat(tx_rd);
  assign txf_empty_i = (tx_rd >= tx_fill);
  assign rxf_full_i  = (rx_n >= rx_room);
  assign tx_smp_ready_i = stall ? ~cyc[0] : 1'b1;
  assign rx_smp_valid_i = stall ? cyc[0] : 1'b1;
  assign rx_smp_i = {rx_pat(src_n, 3), rx_pat(src_n, 2), rx_pat(src_n, 1), rx_pat(src_n, 0)};

  always_ff @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (model_clr) begin
      tx_rd <= 0; rx_n <= 0; tx_n <= 0; src_n <= 0; done_n <= 0; busy_n <= 0;
    end else begin
      if (txf_pop_o) tx_rd <= tx_rd + 1;
      if (rxf_push_o) begin rx_got[rx_n] <= rxf_data_o; rx_n <= rx_n + 1; end
      if (tx_smp_valid_o && tx_smp_ready_i) begin tx_got[tx_n] <= tx_smp_o; tx_n <= tx_n + 1; end
      if (rx_smp_valid_i && rx_smp_ready_o) src_n <= src_n + 1;
      if (done_o) done_n <= done_n + 1;
      if (busy_o) busy_n <= busy_n + 1;
    end
  end

  initial begin
    cyc = 0; tx_rd = 0; rx_n = 0; tx_n = 0; src_n = 0; done_n = 0; busy_n = 0;
  end

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk_i) req_i = 1'b1;
    @(negedge clk_i) req_i = 1'b0;
  endtask

  task automatic run_vec(vec_t v, string tag);
    int nb, exp_pop, seen;
    bit gated, tx_act;
    nb = v.bps + 1;
    gated = v.en && (v.proto == 3'd3);
    tx_act = gated && v.txen && v.txoe && (v.tc > 0);
    exp_pop = tx_act ? ((v.fill < v.tc * nb) ? v.fill : v.tc * nb) : 0;
    @(negedge clk_i);
    en_i = v.en; proto_i = v.proto; tx_en_i = v.txen; tx_oe_i = v.txoe; rx_en_i = v.rxen;
    bps_i = 2'(v.bps); tx_cnt_i = CNT_W'(v.tc); rx_cnt_i = CNT_W'(v.rc); stall = v.stall;
    tx_fill = v.fill; rx_room = v.room; model_clr = 1'b1; err_clr_i = 1'b1;
    @(negedge clk_i) model_clr = 1'b0; err_clr_i = 1'b0;
    @(negedge clk_i) req_i = 1'b1;
    @(negedge clk_i) req_i = 1'b0;
    if (gated) begin
      check("R8", {tag, " busy after request"}, busy_o, 1);
      seen = 0;
      for (int i = 0; i < 400 && !seen; i++) begin
        if (done_o) seen = 1; else @(negedge clk_i);
      end
      @(negedge clk_i);
      check("R8", {tag, " busy clear after done"}, busy_o, 0);
      check("R8", {tag, " done pulses"}, done_n, 1);
    end else begin
      repeat (8) @(negedge clk_i);
      check("R1", {tag, " busy cycles when gated off"}, busy_n, 0);
      check("R1", {tag, " done pulses when gated off"}, done_n, 0);
    end
    check("R3", {tag, " tx samples"}, tx_n, v.ntx);
    for (int s = 0; s < v.ntx && s < tx_n; s++) begin
      logic [SMP_W-1:0] e = '0;
      for (int j = 0; j < nb; j++) e[j*8 +: 8] = tx_pat(s * nb + j);
      check("R3", {tag, " tx sample value"}, tx_got[s], e);
    end
    check("R5", {tag, " tx bytes popped"}, tx_rd, exp_pop);
    check("R4", {tag, " rx bytes pushed"}, rx_n, v.nrx);
    for (int k = 0; k < v.nrx && k < rx_n; k++)
      check("R4", {tag, " rx byte value"}, rx_got[k], rx_pat(k / nb, k % nb));
    check("R5", {tag, " underrun flag"}, udr_o, v.udr);
    check("R6", {tag, " overrun flag"}, ovr_o, v.ovr);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R8 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clr = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i) model_clr = 1'b0;
    // reset state
    check("R8", "reset busy", busy_o, 0);
    check("R8", "reset done", done_o, 0);
    check("R7", "reset underrun", udr_o, 0);
    check("R7", "reset overrun", ovr_o, 0);
    check("R10", "reset quiet", {txf_pop_o, rxf_push_o, tx_smp_valid_o, rx_smp_ready_o}, 0);

    for (int n = 0; n < NV; n++) begin
      string t;
      t = $sformatf("vec%0d", n);
      // R1 gated rows 5,6; R2 rows 7,8; R9 row 4
      run_vec(VECS[n], t);
    end

    // R7/R9: flags from last vector survive a zero-count request
    tx_cnt_i = 0; rx_cnt_i = 0;
    pulse_req();
    repeat (3) @(negedge clk_i);
    check("R9", "zero request keeps underrun", udr_o, 1);
    check("R9", "zero request keeps overrun", ovr_o, 1);
    check("R7", "flags sticky idle", {udr_o, ovr_o}, 2'b11);
    err_clr_i = 1'b1;
    @(negedge clk_i) err_clr_i = 1'b0;
    check("R7", "clear underrun", udr_o, 0);
    check("R7", "clear overrun", ovr_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule